// File: doc/BRIEF.md
# Latched Fault Interrupt Controller

This block gathers a vector of fault-event inputs, one of which is a serial audio bus clock fault on bit 7. Each event is held in a sticky status register. The block turns the pending, unmasked events into a single interrupt request for a host processor. Software programs the block through a small register port:

- a per-source mask;
- a configuration word holding the output polarity, the event shape and an open-drain enable;
- the latched status, which is read-only and clears completely when it is read.

The interrupt can take one of three shapes:

- a short one-shot pulse;
- a square-wave pulse train that repeats until the status is read;
- a level held until the status is read.

The pin stage applies the programmed polarity. It can release the line whenever it is not pulling low, so several devices can share one wired-AND interrupt line.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the configuration reads 0 (active-low, single-pulse, push-pull) and the status reads 0. `irq_o` is 1 (deasserted) and `irq_oe` is 1.
- R2: A status bit whose mask bit is 1 never asserts the interrupt. Clearing the mask bit of an already latched source asserts the interrupt one cycle after the mask write edge.
- R3: A fault input that is high at a clock edge sets its status bit. That bit stays set after the input returns low, and reads back at address 2.
- R4: A read of address 2 (`rd_en` high at an edge) clears every status bit at that edge, except that a fault high in the same cycle stays latched.
- R5: Configuration bit 0 selects polarity: 0 gives active-low `irq_o`, and 1 gives active-high `irq_o`.
- R6: With event field (configuration bits 2:1) equal to 00 or 11, a new unmasked latched fault gives one interrupt pulse of exactly 2 cycles. The pulse starts one cycle after the status bit is set.
- R7: With event field 01 the interrupt is a train with a 16-cycle period, asserted for the first 8 cycles of each period. The train starts one cycle after latching and stops once the status is read.
- R8: With event field 10 the interrupt stays asserted from one cycle after latching until the status read. It is deasserted one cycle after the read edge.
- R9: With configuration bit 3 set (open-drain), `irq_oe` is 1 only while `irq_o` is 0. With bit 3 clear, `irq_oe` is always 1.
- R10: The register map is: address 0 for the mask, address 1 for the configuration, and address 2 for the status. Writes to address 2 have no effect. Reads are combinational on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 8 | Fault event inputs, bit 7 is the bus clock fault |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (clears status when address is 2) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq_o | output | 1 | Interrupt output level after polarity |
| irq_oe | output | 1 | Output enable for the interrupt pin driver |

## Verification
The timing of each result is fixed:

- A fault sampled at edge k is visible in the status from edge k.
- The shaped interrupt is registered once more, so it appears after edge k+1.
- A status read at edge r drops the level or train after edge r+1.
- A mask or configuration write takes effect in the register at its edge, and in the interrupt one edge later.

The bench drives every input just after a falling edge and samples just before the next falling edge. It counts asserted cycles over fixed windows, such as 2 of 12 for a pulse and 16 of 32 for a train, and checks the exact start and gap cycles against these latencies.

// File: rtl/fic_pkg.sv
package fic_pkg;
    typedef enum logic [1:0] {
        EV_PULSE     = 2'b00,
        EV_TRAIN     = 2'b01,
        EV_LEVEL     = 2'b10,
        EV_PULSE_ALT = 2'b11
    } ev_mode_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CFG_POL_BIT  = 0;
    localparam int CFG_MODE_LSB = 1;
    localparam int CFG_OD_BIT   = 3;
endpackage

// File: rtl/fic_regs.sv
module fic_regs
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fault_i,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    output logic [NUM_SRC-1:0] rd_data,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] status_o,
    output logic               pol_o,
    output logic               od_o,
    output ev_mode_e           mode_o,
    output logic               rd_clr_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] status;
        logic               pol;
        logic               od;
        ev_mode_e           mode;
    } regs_t;

    regs_t st_q, st_d;
    logic  rd_clr;

    assign rd_clr = rd_en && (rd_addr == ADDR_STAT);

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_addr == ADDR_MASK) begin
            st_d.mask = wr_data;
        end
        if (wr_en && wr_addr == ADDR_CFG) begin
            st_d.pol  = wr_data[CFG_POL_BIT];
            st_d.od   = wr_data[CFG_OD_BIT];
            st_d.mode = ev_mode_e'(wr_data[CFG_MODE_LSB +: 2]);
        end
        st_d.status = (rd_clr ? '0 : st_q.status) | fault_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask   <= '1;
            st_q.status <= '0;
            st_q.pol    <= 1'b0;
            st_q.od     <= 1'b0;
            st_q.mode   <= EV_PULSE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_MASK: rd_data = st_q.mask;
            ADDR_CFG: begin
                rd_data[CFG_POL_BIT]         = st_q.pol;
                rd_data[CFG_MODE_LSB +: 2]   = st_q.mode;
                rd_data[CFG_OD_BIT]          = st_q.od;
            end
            ADDR_STAT: rd_data = st_q.status;
            default:   rd_data = '0;
        endcase
    end

    assign mask_o   = st_q.mask;
    assign status_o = st_q.status;
    assign pol_o    = st_q.pol;
    assign od_o     = st_q.od;
    assign mode_o   = st_q.mode;
    assign rd_clr_o = rd_clr;

    // R3: a latched bit survives every edge that is not a status read
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));

    // R4: after a status read only the faults of that same cycle remain
    a_r4_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (st_q.status == $past(fault_i)));

    // R10: a write aimed at the status address leaves the mask alone
    a_r10_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_STAT) |=> $stable(st_q.mask));
endmodule

// File: rtl/fic_shaper.sv
module fic_shaper
    import fic_pkg::*;
#(
    parameter int PULSE_LEN    = 2,
    parameter int TRAIN_PERIOD = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pend_i,
    input  logic     restart_i,
    input  ev_mode_e mode_i,
    output logic     act_o
);
    localparam int CNT_MAX = (PULSE_LEN > TRAIN_PERIOD) ? PULSE_LEN : TRAIN_PERIOD;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] P_LEN  = CW'(PULSE_LEN);
    localparam logic [CW-1:0] T_LAST = CW'(TRAIN_PERIOD - 1);
    localparam logic [CW-1:0] T_HIGH = CW'(TRAIN_PERIOD / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } shp_t;

    shp_t sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        case (mode_i)
            EV_TRAIN: sh_d.act = pend_i && (sh_q.cnt < T_HIGH);
            EV_LEVEL: sh_d.act = pend_i;
            default:  sh_d.act = pend_i && (sh_q.cnt < P_LEN);
        endcase
        if (!pend_i || restart_i) begin
            sh_d.cnt = '0;
        end else begin
            case (mode_i)
                EV_TRAIN: sh_d.cnt = (sh_q.cnt >= T_LAST) ? '0 : sh_q.cnt + 1'b1;
                EV_LEVEL: sh_d.cnt = sh_q.cnt;
                default:  sh_d.cnt = (sh_q.cnt >= P_LEN) ? sh_q.cnt : sh_q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign act_o = sh_q.act;

    // R2: nothing pending means no interrupt on the following cycle
    a_r2_no_pend_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_i |=> !sh_q.act);

    // R6: in one-shot mode the pulse never runs past two cycles
    a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[0] == mode_i[1] && $past(mode_i[0] == mode_i[1]) &&
         $past(mode_i[0] == mode_i[1], 2) && $past(sh_q.act) && $past(sh_q.act, 2))
        |-> !sh_q.act);

    // R8: level mode follows the pending state one cycle later
    a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EV_LEVEL) |=> (sh_q.act == $past(pend_i)));
endmodule

// File: rtl/fic_pin.sv
module fic_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pol_i,
    input  logic od_i,
    output logic irq_o,
    output logic irq_oe
);
    assign irq_o  = pol_i ? act_i : ~act_i;
    assign irq_oe = od_i ? ~irq_o : 1'b1;

    // R9: an open-drain pin is never driven high
    a_r9_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (od_i && irq_o) |-> !irq_oe);

    // R9: a push-pull pin is always driven
    a_r9_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !od_i |-> irq_oe);

    // R5: the pin level agrees with the shaped request under either polarity
    a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (irq_o == pol_i));
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
    import fic_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int PULSE_LEN    = 2,
    parameter int TRAIN_PERIOD = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fault_i,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    output logic [NUM_SRC-1:0] rd_data,
    output logic               irq_o,
    output logic               irq_oe
);
    logic [NUM_SRC-1:0] mask, status;
    logic               pol, od, rd_clr, pend, act;
    ev_mode_e           mode;

    fic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (fault_i),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .mask_o   (mask),
        .status_o (status),
        .pol_o    (pol),
        .od_o     (od),
        .mode_o   (mode),
        .rd_clr_o (rd_clr)
    );

    assign pend = |(status & ~mask);

    fic_shaper #(.PULSE_LEN(PULSE_LEN), .TRAIN_PERIOD(TRAIN_PERIOD)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .restart_i (rd_clr),
        .mode_i    (mode),
        .act_o     (act)
    );

    fic_pin u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .pol_i  (pol),
        .od_i   (od),
        .irq_o  (irq_o),
        .irq_oe (irq_oe)
    );
endmodule

// File: tb/sim_fault_irq_ctrl.sv
module sim_fault_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fault_i = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_o, irq_oe;

    int n_checks = 0;
    int n_errs   = 0;
    logic cur_pol = 1'b0;

    fault_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic on();
        return irq_o == cur_pol;
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic read_clear(output logic [7:0] d);
        rd_addr = 2'd2; rd_en = 1'b1; #1; d = rd_data;
        step();
        rd_en = 1'b0;
    endtask

    task automatic cfg(logic od, logic [1:0] mode, logic pol);
        wr(2'd1, {4'b0, od, mode, pol});
        cur_pol = pol;
    endtask

    task automatic hit(logic [7:0] f);
        fault_i = f;
        step();
        fault_i = '0;
    endtask

    task automatic count_on(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (on()) c++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd0, d); check("R1 mask reset", d, 8'hFF);
        peek(2'd1, d); check("R1 cfg reset", d, 8'h00);
        peek(2'd2, d); check("R1 status reset", d, 8'h00);
        check("R1 irq_o idle", irq_o, 1'b1);
        check("R1 irq_oe push-pull", irq_oe, 1'b1);
    endtask

    task automatic t_masked();
        logic [7:0] d; int c;
        hit(8'h80);
        count_on(10, c);
        check("R2 masked no irq", c, 0);
        peek(2'd2, d); check("R3 sticky clock fault", d, 8'h80);
        read_clear(d); check("R3 read value", d, 8'h80);
        peek(2'd2, d); check("R4 cleared", d, 8'h00);
    endtask

    task automatic t_pulse(logic [1:0] mode);
        logic [7:0] d; int c;
        cfg(1'b0, mode, 1'b0);
        wr(2'd0, 8'h7F);
        hit(8'h80);
        step(); c = on() ? 1 : 0;
        check("R6 pulse starts one cycle after latch", c, 1);
        begin int rest; count_on(11, rest); c += rest; end
        check("R6 pulse width", c, 2);
        read_clear(d);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_train();
        logic [7:0] d; int c; int s8; int s16;
        cfg(1'b0, 2'b01, 1'b0);
        wr(2'd0, 8'h7F);
        hit(8'h80);
        c = 0; s8 = -1; s16 = -1;
        for (int i = 0; i < 32; i++) begin
            step();
            if (on()) c++;
            if (i == 0) check("R7 train first cycle", on(), 1'b1);
            if (i == 8) s8 = on() ? 1 : 0;
            if (i == 16) s16 = on() ? 1 : 0;
        end
        check("R7 train duty over two periods", c, 16);
        check("R7 train gap at cycle 8", s8, 0);
        check("R7 train restarts at cycle 16", s16, 1);
        read_clear(d);
        count_on(20, c);
        check("R7 train stops after read", c, 0);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_level();
        logic [7:0] d; int c;
        cfg(1'b0, 2'b10, 1'b0);
        wr(2'd0, 8'hFE);
        hit(8'h01);
        count_on(20, c);
        check("R8 level held", c, 20);
        read_clear(d);
        step();
        check("R8 released one cycle after read", on(), 1'b0);
        count_on(10, c);
        check("R8 stays released", c, 0);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_unmask();
        logic [7:0] d; int c;
        cfg(1'b0, 2'b10, 1'b0);
        hit(8'h04);
        count_on(5, c);
        check("R2 masked latched source silent", c, 0);
        wr(2'd0, 8'hFB);
        step();
        check("R2 unmask asserts irq", on(), 1'b1);
        read_clear(d);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        hit(8'h01);
        fault_i = 8'h02;
        read_clear(d);
        fault_i = '0;
        check("R4 read value before clear", d, 8'h01);
        peek(2'd2, d);
        check("R4 same-cycle fault kept", d, 8'h02);
        read_clear(d);
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        cfg(1'b0, 2'b10, 1'b1);
        step();
        check("R5 active-high idle low", irq_o, 1'b0);
        wr(2'd0, 8'h7F);
        hit(8'h80);
        step();
        check("R5 active-high asserted", irq_o, 1'b1);
        read_clear(d);
        wr(2'd0, 8'hFF);
        cfg(1'b0, 2'b00, 1'b0);
    endtask

    task automatic t_open_drain();
        logic [7:0] d;
        cfg(1'b1, 2'b10, 1'b0);
        step();
        check("R9 od idle level", irq_o, 1'b1);
        check("R9 od idle released", irq_oe, 1'b0);
        wr(2'd0, 8'h7F);
        hit(8'h80);
        step();
        check("R9 od asserted low", irq_o, 1'b0);
        check("R9 od driving", irq_oe, 1'b1);
        read_clear(d);
        step();
        check("R9 od released after read", irq_oe, 1'b0);
        wr(2'd0, 8'hFF);
        cfg(1'b0, 2'b00, 1'b0);
        check("R9 push-pull drives", irq_oe, 1'b1);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(2'd2, 8'hFF);
        peek(2'd2, d); check("R10 status write ignored", d, 8'h00);
        wr(2'd0, 8'h5A);
        peek(2'd0, d); check("R10 mask readback", d, 8'h5A);
        cfg(1'b1, 2'b01, 1'b1);
        peek(2'd1, d); check("R10 cfg readback", d, 8'h0B);
        cfg(1'b0, 2'b00, 1'b0);
        wr(2'd0, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_masked();
        t_pulse(2'b00);
        t_pulse(2'b11);
        t_train();
        t_level();
        t_unmask();
        t_same_cycle();
        t_polarity();
        t_open_drain();
        t_regmap();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule